// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This block sits between a processor core and a data memory that is addressed in whole words. On the store side it takes the low bits of the effective address, the access size and the store data. It produces the aligned write word and one write enable per byte lane. On the load side it takes the word read from memory, the same low address bits, the access size and a signedness flag. It returns the selected byte, halfword or word, right-aligned and extended to the full register width.

Byte order is big-endian. Byte offset 0 inside a word is the most significant byte. A naturally aligned halfword at offset 0 therefore occupies the upper half of the word. If the access is not naturally aligned, the unit raises a misalignment flag and suppresses every write enable. Raising the exception is left to the core.

All outputs are registered. They present the result for the inputs of one clock edge after that edge.

Top module: `be_lane_unit`

## Requirements
- R1: While `rst_n` is low, `wr_word`, `wr_be`, `ld_value` and `misalign` are all zero.
- R2: Size encoding is 0 = byte, 1 = halfword, 2 = word. Lane j means `wr_word[8j+7:8j]` and is enabled by `wr_be[j]`. Byte offset k maps to lane `LANES-1-k`. A byte store sets only the enable of lane `LANES-1-addr_lo`, places `st_data[7:0]` on that lane and drives all other lanes to zero.
- R3: A halfword store with `addr_lo[0]=0` enables the two lanes of the halfword. With `addr_lo[1]=0` these are bits 31:16; with `addr_lo[1]=1` they are bits 15:0. The store places `st_data[15:8]` on the lower-offset (more significant) lane and `st_data[7:0]` on the other.
- R4: An aligned word store enables all lanes and writes `st_data` unchanged.
- R5: A halfword access with `addr_lo[0]=1`, a word access with `addr_lo` nonzero, or size code 3 sets `misalign`. In that case `wr_be`, `wr_word` and `ld_value` are zero.
- R6: When `st_req` is low, `wr_be` and `wr_word` are zero, whatever the other inputs are.
- R7: A byte load returns the byte at offset `addr_lo`. With `ld_signed=1` it is sign-extended; with `ld_signed=0` it is zero-extended.
- R8: An aligned halfword load returns the halfword at offset `addr_lo`, with the lower-offset byte as its upper byte. It is sign-extended when `ld_signed=1` and zero-extended otherwise.
- R9: An aligned word load returns `rd_word` unchanged.
- R10: Every output reflects the inputs present at the previous rising clock edge.
- R11: A store followed by a load of the same size and offset returns the stored value. After the word 5 is stored at a word-aligned address, a byte load at offset 0 returns 0x00 and a byte load at offset 3 returns 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_req | input | 1 | Current access is a store |
| addr_lo | input | OFS_W (2) | Byte offset within the word |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| ld_signed | input | 1 | Sign-extend byte/halfword loads |
| st_data | input | DATA_W (32) | Store data, right-aligned |
| rd_word | input | DATA_W (32) | Word read from memory |
| wr_word | output | DATA_W (32) | Lane-aligned write data |
| wr_be | output | LANES (4) | Per-lane write enables |
| ld_value | output | DATA_W (32) | Aligned, extended load result |
| misalign | output | 1 | Access is not naturally aligned |

## Verification
The bench builds the unit with the default `DATA_W` of 32, which gives four lanes and a two-bit offset. At that width it can sweep every offset against every size code and both signedness settings. This includes each misaligned combination and the reserved size code. A small byte-array memory model in the bench applies the enables, so store-then-load round trips and the big-endian lane order are checked end to end. Data patterns with the top bit of the byte or halfword set separate sign extension from zero extension.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/be_align_chk.sv
module be_align_chk
    import be_lane_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] addr_lo,
    input  acc_size_e        size,
    output logic             bad
);
    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = addr_lo[0];
            SZ_FULL: bad = |addr_lo;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/be_store_lane.sv
module be_store_lane
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  logic [OFS_W-1:0]  addr_lo,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] word,
    output logic [LANES-1:0]  be
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int K = LANES - 1 - j;
        logic       hit;
        logic [7:0] dat;
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    hit = (int'(addr_lo) == K);
                    dat = st_data[7:0];
                end
                SZ_HALF: begin
                    hit = ((int'(addr_lo) >> 1) == (K >> 1));
                    dat = ((K % 2) == 0) ? st_data[15:8] : st_data[7:0];
                end
                SZ_FULL: begin
                    hit = 1'b1;
                    dat = st_data[8*j +: 8];
                end
                default: begin
                    hit = 1'b0;
                    dat = 8'h00;
                end
            endcase
        end
        assign word[8*j +: 8] = hit ? dat : 8'h00;
        assign be[j]          = hit;
    end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  logic [OFS_W-1:0]  addr_lo,
    input  acc_size_e         size,
    input  logic              sgn,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] value
);
    int          byte_lane;
    int          half_lane;
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        byte_lane = LANES - 1 - int'(addr_lo);
        half_lane = LANES - 2 - (int'(addr_lo) & ~1);
        sel_b     = rd_word[8*byte_lane +: 8];
        sel_h     = rd_word[8*half_lane +: 16];
        case (size)
            SZ_BYTE: value = {{(DATA_W-8){sgn & sel_b[7]}}, sel_b};
            SZ_HALF: value = {{(DATA_W-16){sgn & sel_h[15]}}, sel_h};
            SZ_FULL: value = rd_word;
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic [1:0]        acc_size,
    input  logic              ld_signed,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_word,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] ld_value,
    output logic              misalign
);
    typedef struct packed {
        logic [DATA_W-1:0] wr_word;
        logic [LANES-1:0]  wr_be;
        logic [DATA_W-1:0] ld_value;
        logic              misalign;
    } out_s;

    acc_size_e         size_e;
    logic              bad;
    logic [DATA_W-1:0] st_word;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] ld_word;
    out_s              out_d, out_q;

    assign size_e = acc_size_e'(acc_size);

    be_align_chk #(.OFS_W(OFS_W)) u_align (
        .addr_lo (addr_lo),
        .size    (size_e),
        .bad     (bad)
    );

    be_store_lane #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_store (
        .addr_lo (addr_lo),
        .size    (size_e),
        .st_data (st_data),
        .word    (st_word),
        .be      (st_be)
    );

    be_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_load (
        .addr_lo (addr_lo),
        .size    (size_e),
        .sgn     (ld_signed),
        .rd_word (rd_word),
        .value   (ld_word)
    );

    always_comb begin
        out_d          = '0;
        out_d.misalign = bad;
        if (!bad) begin
            out_d.ld_value = ld_word;
            if (st_req) begin
                out_d.wr_word = st_word;
                out_d.wr_be   = st_be;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wr_word  = out_q.wr_word;
    assign wr_be    = out_q.wr_be;
    assign ld_value = out_q.ld_value;
    assign misalign = out_q.misalign;

    // R5
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (wr_be == '0 && ld_value == '0));

    // R2
    byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && acc_size == 2'd0) |=> $countones(wr_be) == 1);

    // R4
    full_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && acc_size == 2'd2 && addr_lo == '0) |=> (&wr_be && wr_word == $past(st_data)));

    // R6
    no_store_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req |=> (wr_be == '0 && wr_word == '0));

    // R8
    half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'd1 && !addr_lo[0] && !ld_signed) |=> ld_value[DATA_W-1:16] == '0);
endmodule

// File: tb/sim_be_lane_unit.sv
module sim_be_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic        ld_signed = 1'b0;
    logic [31:0] st_data = '0;
    logic [31:0] rd_word = '0;
    logic [31:0] wr_word;
    logic [3:0]  wr_be;
    logic [31:0] ld_value;
    logic        misalign;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0] mem [4];

    always #4 clk = ~clk;

    be_lane_unit u0 (
        .clk(clk), .rst_n(rst_n), .st_req(st_req), .addr_lo(addr_lo),
        .acc_size(acc_size), .ld_signed(ld_signed), .st_data(st_data),
        .rd_word(rd_word), .wr_word(wr_word), .wr_be(wr_be),
        .ld_value(ld_value), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at negedge, result visible at the following negedge
    task automatic apply(input logic s, input int a, input int sz, input logic sg,
                         input logic [31:0] sd, input logic [31:0] rw);
        @(negedge clk);
        st_req = s; addr_lo = 2'(a); acc_size = 2'(sz);
        ld_signed = sg; st_data = sd; rd_word = rw;
        @(negedge clk);
    endtask

    function automatic logic [31:0] mem_word();
        return {mem[0], mem[1], mem[2], mem[3]};
    endfunction

    task automatic commit();
        for (int k = 0; k < 4; k++)
            if (wr_be[3-k]) mem[k] = wr_word[31-8*k -: 8];
    endtask

    task automatic t_reset();
        st_req = 1'b1; acc_size = 2'd2; st_data = 32'hFFFF_FFFF; rd_word = 32'hFFFF_FFFF;
        #20;
        chk("R1 wr_word", wr_word, 0);
        chk("R1 wr_be", {28'd0, wr_be}, 0);
        chk("R1 ld_value", ld_value, 0);
        chk("R1 misalign", {31'd0, misalign}, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_byte_store();
        for (int a = 0; a < 4; a++) begin
            apply(1, a, 0, 0, 32'h1234_56A5, 0);
            chk("R2 be", {28'd0, wr_be}, 32'(4'b1000 >> a));
            chk("R2 word", wr_word, 32'hA500_0000 >> (8*a));
            chk("R2 misalign", {31'd0, misalign}, 0);
        end
    endtask

    task automatic t_half_store();
        apply(1, 0, 1, 0, 32'hFFFF_BEEF, 0);
        chk("R3 be hi", {28'd0, wr_be}, 32'hC);
        chk("R3 word hi", wr_word, 32'hBEEF_0000);
        apply(1, 2, 1, 0, 32'h0000_C0DE, 0);
        chk("R3 be lo", {28'd0, wr_be}, 32'h3);
        chk("R3 word lo", wr_word, 32'h0000_C0DE);
    endtask

    task automatic t_word_store();
        apply(1, 0, 2, 0, 32'hDEAD_BEEF, 0);
        chk("R4 be", {28'd0, wr_be}, 32'hF);
        chk("R4 word", wr_word, 32'hDEAD_BEEF);
    endtask

    task automatic t_misalign();
        for (int a = 0; a < 4; a++) begin
            for (int sz = 1; sz < 4; sz++) begin
                bit exp_bad = (sz == 3) || (sz == 1 && a[0]) || (sz == 2 && a != 0);
                apply(1, a, sz, 1, 32'hFFFF_FFFF, 32'h8080_8080);
                chk("R5 flag", {31'd0, misalign}, {31'd0, exp_bad});
                if (exp_bad) begin
                    chk("R5 be", {28'd0, wr_be}, 0);
                    chk("R5 word", wr_word, 0);
                    chk("R5 ld", ld_value, 0);
                end
            end
        end
    endtask

    task automatic t_no_store();
        for (int sz = 0; sz < 3; sz++) begin
            apply(0, 0, sz, 0, 32'hFFFF_FFFF, 32'h0102_0304);
            chk("R6 be", {28'd0, wr_be}, 0);
            chk("R6 word", wr_word, 0);
        end
    endtask

    task automatic t_loads();
        logic [31:0] w = 32'h81F2_7F04;
        logic [7:0]  bytes [4] = '{8'h81, 8'hF2, 8'h7F, 8'h04};
        for (int a = 0; a < 4; a++) begin
            apply(0, a, 0, 1, 0, w);
            chk("R7 signed", ld_value, {{24{bytes[a][7]}}, bytes[a]});
            apply(0, a, 0, 0, 0, w);
            chk("R7 unsigned", ld_value, {24'd0, bytes[a]});
        end
        apply(0, 0, 1, 1, 0, w);
        chk("R8 hi signed", ld_value, 32'hFFFF_81F2);
        apply(0, 2, 1, 1, 0, w);
        chk("R8 lo signed", ld_value, 32'h0000_7F04);
        apply(0, 0, 1, 0, 0, w);
        chk("R8 hi unsigned", ld_value, 32'h0000_81F2);
        apply(0, 0, 2, 1, 0, w);
        chk("R9 word", ld_value, w);
    endtask

    task automatic t_latency();
        @(negedge clk);
        st_req = 1; addr_lo = 2'd1; acc_size = 2'd0; st_data = 32'h0000_0077;
        @(posedge clk); #1;
        chk("R10 after edge", {28'd0, wr_be}, 32'h4);
        st_req = 0;
        @(negedge clk);
        chk("R10 held", {28'd0, wr_be}, 32'h4);
        @(posedge clk); #1;
        chk("R10 next", {28'd0, wr_be}, 0);
    endtask

    task automatic t_roundtrip();
        for (int k = 0; k < 4; k++) mem[k] = 8'hEE;
        apply(1, 0, 2, 0, 32'h0000_0005, 0);
        commit();
        apply(0, 0, 0, 1, 0, mem_word());
        chk("R11 byte0", ld_value, 32'h0);
        apply(0, 3, 0, 1, 0, mem_word());
        chk("R11 byte3", ld_value, 32'h5);
        apply(1, 2, 0, 0, 32'h0000_00C3, 0);
        commit();
        apply(0, 2, 0, 0, 0, mem_word());
        chk("R11 byte2 rt", ld_value, 32'h0000_00C3);
        chk("R11 mem", mem_word(), 32'h0000_C305);
        apply(1, 0, 1, 0, 32'h0000_9A5B, 0);
        commit();
        apply(0, 0, 1, 1, 0, mem_word());
        chk("R11 half rt", ld_value, 32'hFFFF_9A5B);
    endtask

    initial begin
        t_reset();
        t_byte_store();
        t_half_store();
        t_word_store();
        t_misalign();
        t_no_store();
        t_loads();
        t_latency();
        t_roundtrip();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule